// File: doc/BRIEF.md
# Iterative Decimal-to-Binary Converter

This block turns an unsigned packed-BCD integer of up to 34 decimal digits into its binary value. The operand is split into groups of three digits, and the most significant group is handled first. In each busy cycle the running value is multiplied by one thousand and the next three-digit group is added. The running value stays in redundant carry-save form (a sum vector and a carry vector), so no carry ever ripples inside the loop. Every weight (×1000, ×100, ×10) is rebuilt from a few shifted copies of the operands, and one of those copies is subtracted. A single carry-propagate addition at the end gives the binary result.

A caller pulses `start` while the block is idle and supplies the operand and a digit count. `busy` stays high while the conversion runs. `done` is high for one cycle when `result` is valid. With the result, the block compares the modulo-3 residue of the decimal operand with the modulo-3 residue of the binary result, and it raises `chk_err` if the two differ.

Top module: `dec2bin_iter`

## Requirements
- R1: When `done` is high, `result` equals the binary value of the operand. Digit i sits at `bcd_in[4i+3:4i]`, digit 0 is the least significant, and every digit is in the range 0 to 9.
- R2: Digits at positions at or above the effective digit count are treated as zero, whatever their contents.
- R3: A `digit_cnt` above 34 is treated as 34. A `digit_cnt` of 0 gives a result of 0.
- R4: A `start` accepted at a clock edge while idle makes `busy` high from that edge on. `done` then rises G+1 edges later, where G = max(1, ceil(k/3)) and k is the effective digit count. One three-digit group is absorbed per cycle.
- R5: `done` is high for exactly one cycle. `result` and `chk_err` keep their values until the next conversion completes.
- R6: A `start` that arrives while `busy` is high is ignored. It produces no extra `done`, and it does not change the result in flight.
- R7: `chk_err` is 0 whenever the binary result is congruent, modulo 3, to the decimal operand. This holds for every valid conversion.
- R8: After a synchronous active-low reset, `busy`, `done` and `chk_err` are 0 and `result` is 0.
- R9: The largest operand, 34 nines, converts to 10^34 - 1 without overflow in the 113-bit result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a conversion; taken only while idle |
| bcd_in | input | 136 | Packed BCD operand, 4 bits per digit, digit 0 in the low nibble |
| digit_cnt | input | 6 | Number of significant digits, k |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse: result valid |
| result | output | 113 | Binary value of the operand |
| chk_err | output | 1 | Modulo-3 residue mismatch, valid with done |

## Verification
The `done` pulse of one conversion and the acceptance of the next `start` can fall in the same cycle, because `busy` is already low while `done` is high. The bench provokes this by issuing each new start at the very sample where it sees `done`, during a long run of conversions with random digit counts. It judges the result by comparing the popped value and the completion cycle of every conversion with independently computed expectations. It also checks that the finished result stays unchanged in the cycle after the pulse, even though the next conversion is already loading.

// File: rtl/dec2bin_pkg.sv
// Package: shared types for the iterative decimal-to-binary converter.
// Assumes nothing beyond standard enum encoding.
package dec2bin_pkg;

    // Control states of the conversion sequencer
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } d2b_state_e;

    // Smallest number of result bits able to hold NUM_DIGITS decimal digits
    function automatic int res_bits(input int num_digits);
        return (num_digits * 3322) / 1000 + 1;
    endfunction

endpackage

// File: rtl/d2b_operand_prep.sv
// Module: d2b_operand_prep
// Clamps the digit count, zeroes digits at or above it, pads the operand
// to a whole number of three-digit groups, finds the index of the top
// group, and forms the modulo-3 residue of the decimal operand (the digit
// sum, since ten is congruent to one).
// Assumes every nibble holds a valid BCD digit.
module d2b_operand_prep #(
    parameter int NUM_DIGITS = 34,
    parameter int CNT_W      = 6,
    parameter int PAD_DIGITS = 36,
    parameter int GRP_W      = 4
) (
    input  logic [4*NUM_DIGITS-1:0] bcd_in,
    input  logic [CNT_W-1:0]        digit_cnt,
    output logic [4*PAD_DIGITS-1:0] op_masked,
    output logic [GRP_W-1:0]        last_grp,
    output logic [1:0]              dec_res
);

    int keff;
    int ngrp;
    int dsum;

    // Mask, pad, group count and digit-sum residue
    always_comb begin
        keff = (int'(digit_cnt) > NUM_DIGITS) ? NUM_DIGITS : int'(digit_cnt);
        op_masked = '0;
        dsum = 0;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (i < keff) begin
                op_masked[4*i +: 4] = bcd_in[4*i +: 4];
                dsum = dsum + int'(bcd_in[4*i +: 4]);
            end
        end
        ngrp = (keff + 2) / 3;
        if (ngrp == 0) begin
            ngrp = 1;
        end
        last_grp = GRP_W'(ngrp - 1);
        dec_res  = 2'(dsum % 3);
    end

endmodule

// File: rtl/d2b_group_mux.sv
// Module: d2b_group_mux
// Picks the three BCD digits of the group named by grp from the padded
// operand. Group g covers digits 3g+2 (hundreds) down to 3g (units).
// Assumes grp < NUM_GROUPS; other indices select zero.
module d2b_group_mux #(
    parameter int NUM_GROUPS = 12,
    parameter int GRP_W      = 4
) (
    input  logic [12*NUM_GROUPS-1:0] op,
    input  logic [GRP_W-1:0]         grp,
    output logic [3:0]               d_hi,
    output logic [3:0]               d_mid,
    output logic [3:0]               d_lo
);

    logic [11:0] grp_vec [NUM_GROUPS];
    logic [11:0] sel;

    // Slice the operand into group vectors
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_slice
        assign grp_vec[g] = op[12*g +: 12];
    end

    // One-hot style selection of the active group
    always_comb begin
        sel = '0;
        for (int j = 0; j < NUM_GROUPS; j++) begin
            if (GRP_W'(j) == grp) begin
                sel = grp_vec[j];
            end
        end
        {d_hi, d_mid, d_lo} = sel;
    end

endmodule

// File: rtl/d2b_csa_step.sv
// Module: d2b_csa_step
// One conversion iteration in carry-save form:
//   next = (sum + carry) * 1000 + hi*100 + mid*10 + lo     (mod 2^W)
// with x1000 = x1024 - x32 + x8 on both vectors, x100 = x64 + x32 + x4 and
// x10 = x8 + x2. The two subtracted terms enter as bitwise inverses; their
// +1 corrections ride in bit 0 of the first two carry vectors, which the
// left shift leaves empty. All twelve terms fold into one sum/carry pair
// through a chain of 3:2 counters.
// Assumes the true running value fits in W bits.
module d2b_csa_step #(
    parameter int W = 113
) (
    input  logic [W-1:0] sum_in,
    input  logic [W-1:0] carry_in,
    input  logic [3:0]   d_hi,
    input  logic [3:0]   d_mid,
    input  logic [3:0]   d_lo,
    output logic [W-1:0] sum_out,
    output logic [W-1:0] carry_out
);

    localparam int NT = 12;
    localparam int NS = NT - 2;

    logic [W-1:0] term [NT];
    logic [W-1:0] ps   [NS+1];
    logic [W-1:0] pc   [NS+1];

    // Shifted and inverted addends
    always_comb begin
        term[0]  = sum_in   << 10;
        term[1]  = carry_in << 10;
        term[2]  = ~(sum_in   << 5);
        term[3]  = ~(carry_in << 5);
        term[4]  = sum_in   << 3;
        term[5]  = carry_in << 3;
        term[6]  = W'(d_hi) << 6;
        term[7]  = W'(d_hi) << 5;
        term[8]  = W'(d_hi) << 2;
        term[9]  = W'(d_mid) << 3;
        term[10] = W'(d_mid) << 1;
        term[11] = W'(d_lo);
    end

    assign ps[0] = term[0];
    assign pc[0] = term[1];

    // 3:2 counter chain; the first two stages inject the two's-complement ones
    for (genvar k = 0; k < NS; k++) begin : g_stage
        logic [W-1:0] maj;
        assign ps[k+1] = ps[k] ^ pc[k] ^ term[k+2];
        assign maj     = (ps[k] & pc[k]) | (ps[k] & term[k+2]) | (pc[k] & term[k+2]);
        if (k < 2) begin : g_inj
            assign pc[k+1] = (maj << 1) | W'(1);
        end else begin : g_plain
            assign pc[k+1] = maj << 1;
        end
    end

    assign sum_out   = ps[NS];
    assign carry_out = pc[NS];

endmodule

// File: rtl/d2b_mod3.sv
// Module: d2b_mod3
// Residue of a binary value modulo 3: even bit positions weigh 1 and odd
// positions weigh 2, because 2^i alternates between 1 and 2 modulo 3.
// Assumes nothing about the value.
module d2b_mod3 #(
    parameter int W = 113
) (
    input  logic [W-1:0] val,
    output logic [1:0]   res
);

    int acc;

    // Weighted bit count folded modulo 3
    always_comb begin
        acc = 0;
        for (int i = 0; i < W; i++) begin
            if (val[i]) begin
                acc = acc + (((i % 2) == 0) ? 1 : 2);
            end
        end
        res = 2'(acc % 3);
    end

endmodule

// File: rtl/dec2bin_iter.sv
// Module: dec2bin_iter (top)
// Iterative BCD-to-binary converter. It takes three digits per cycle, top
// group first, keeps the running value in carry-save form, and resolves it
// with one carry-propagate addition in a final cycle. It also compares the
// modulo-3 residues of the input and the output.
// Assumes: start is taken only while idle, and the digits are valid BCD.
module dec2bin_iter #(
    parameter int NUM_DIGITS = 34,
    parameter int CNT_W      = $clog2(NUM_DIGITS + 1),
    parameter int RES_W      = dec2bin_pkg::res_bits(NUM_DIGITS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [4*NUM_DIGITS-1:0] bcd_in,
    input  logic [CNT_W-1:0]        digit_cnt,
    output logic                    busy,
    output logic                    done,
    output logic [RES_W-1:0]        result,
    output logic                    chk_err
);
    import dec2bin_pkg::*;

    localparam int NUM_GROUPS = (NUM_DIGITS + 2) / 3;
    localparam int PAD_DIGITS = 3 * NUM_GROUPS;
    localparam int GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
    localparam int ACC_W      = RES_W;

    d2b_state_e              state_q;
    logic [4*PAD_DIGITS-1:0] op_q;
    logic [GRP_W-1:0]        grp_q;
    logic [ACC_W-1:0]        sum_q;
    logic [ACC_W-1:0]        carry_q;
    logic [1:0]              dec_res_q;

    logic [4*PAD_DIGITS-1:0] op_masked;
    logic [GRP_W-1:0]        last_grp;
    logic [1:0]              dec_res;
    logic [3:0]              d_hi;
    logic [3:0]              d_mid;
    logic [3:0]              d_lo;
    logic [ACC_W-1:0]        nxt_sum;
    logic [ACC_W-1:0]        nxt_carry;
    logic [ACC_W-1:0]        cpa;
    logic [1:0]              bin_res;

    d2b_operand_prep #(
        .NUM_DIGITS (NUM_DIGITS),
        .CNT_W      (CNT_W),
        .PAD_DIGITS (PAD_DIGITS),
        .GRP_W      (GRP_W)
    ) u_prep (
        .bcd_in    (bcd_in),
        .digit_cnt (digit_cnt),
        .op_masked (op_masked),
        .last_grp  (last_grp),
        .dec_res   (dec_res)
    );

    d2b_group_mux #(
        .NUM_GROUPS (NUM_GROUPS),
        .GRP_W      (GRP_W)
    ) u_mux (
        .op    (op_q),
        .grp   (grp_q),
        .d_hi  (d_hi),
        .d_mid (d_mid),
        .d_lo  (d_lo)
    );

    d2b_csa_step #(
        .W (ACC_W)
    ) u_csa (
        .sum_in    (sum_q),
        .carry_in  (carry_q),
        .d_hi      (d_hi),
        .d_mid     (d_mid),
        .d_lo      (d_lo),
        .sum_out   (nxt_sum),
        .carry_out (nxt_carry)
    );

    // Final carry-propagate addition of the redundant pair
    assign cpa = sum_q + carry_q;

    d2b_mod3 #(
        .W (ACC_W)
    ) u_mod3 (
        .val (cpa),
        .res (bin_res)
    );

    // Busy whenever the sequencer is away from idle
    assign busy = (state_q != ST_IDLE);

    // Sequencer: load, iterate one group per cycle, resolve and publish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_q      <= '0;
            grp_q     <= '0;
            sum_q     <= '0;
            carry_q   <= '0;
            dec_res_q <= '0;
            result    <= '0;
            chk_err   <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q      <= op_masked;
                        grp_q     <= last_grp;
                        sum_q     <= '0;
                        carry_q   <= '0;
                        dec_res_q <= dec_res;
                        state_q   <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    sum_q   <= nxt_sum;
                    carry_q <= nxt_carry;
                    if (grp_q == '0) begin
                        state_q <= ST_FINISH;
                    end else begin
                        grp_q <= grp_q - 1'b1;
                    end
                end
                ST_FINISH: begin
                    result  <= cpa;
                    chk_err <= (bin_res != dec_res_q);
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R1: each iteration preserves value*1000 + group in the redundant pair
    a_r1_csa_invariant: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> ((sum_q + carry_q) ==
            $past((sum_q + carry_q) * ACC_W'(1000) + ACC_W'(d_hi) * ACC_W'(100)
                  + ACC_W'(d_mid) * ACC_W'(10) + ACC_W'(d_lo))));

    // R4: an accepted start raises busy
    a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R4: the group index steps down by one per cycle while iterating
    a_r4_group_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && grp_q != '0) |=> (grp_q == GRP_W'($past(grp_q) - 1'b1)));

    // R5: done is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: the published result holds while idle
    a_r5_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(result));

    // R6: the loaded operand is untouched while busy
    a_r6_operand_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(op_q));

    // R7: residues of input and output agree on every completion
    a_r7_residue_ok: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !chk_err);

endmodule

// File: tb/tb_dec2bin_iter.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops
// and compares them when done pulses.
module tb_dec2bin_iter;

    localparam int ND    = 34;
    localparam int CW    = 6;
    localparam int RW    = 113;

    typedef struct {
        logic [127:0] val;
        int           due;
        string        tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [4*ND-1:0] bcd_in = '0;
    logic [CW-1:0]   digit_cnt = '0;
    logic            busy;
    logic            done;
    logic [RW-1:0]   result;
    logic            chk_err;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   n_done = 0;
    int   n_launch = 0;
    exp_t sb [$];

    dec2bin_iter #(.NUM_DIGITS(ND)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .bcd_in    (bcd_in),
        .digit_cnt (digit_cnt),
        .busy      (busy),
        .done      (done),
        .result    (result),
        .chk_err   (chk_err)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [127:0] ref_val(input logic [4*ND-1:0] b, input int k);
        logic [127:0] v = '0;
        int keff = (k > ND) ? ND : k;
        for (int i = keff - 1; i >= 0; i--) begin
            v = v * 128'd10 + 128'(b[4*i +: 4]);
        end
        return v;
    endfunction

    function automatic logic [4*ND-1:0] rand_bcd();
        logic [4*ND-1:0] b;
        for (int i = 0; i < ND; i++) begin
            b[4*i +: 4] = 4'($urandom_range(0, 9));
        end
        return b;
    endfunction

    // Driver: called at a negedge while the DUT is idle (or pulsing done)
    task automatic launch(input logic [4*ND-1:0] b, input int k, input string tag);
        exp_t it;
        int   keff = (k > ND) ? ND : k;
        int   g = (keff + 2) / 3;
        if (g == 0) g = 1;
        it.val = ref_val(b, k);
        it.due = cyc + g + 2;
        it.tag = tag;
        sb.push_back(it);
        n_launch++;
        bcd_in    = b;
        digit_cnt = CW'(k);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R4", 128'(busy), 128'd1);
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    // Monitor: compare completions against the scoreboard
    logic          prev_done = 1'b0;
    logic [RW-1:0] prev_res = '0;
    logic          prev_err = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) begin
                check(!done, "R5", 128'(done), 128'd0);
                check(result == prev_res && chk_err == prev_err, "R5",
                      128'(result), 128'(prev_res));
            end
            prev_done = done;
            if (done) begin
                exp_t it;
                n_done++;
                prev_res = result;
                prev_err = chk_err;
                if (sb.size() == 0) begin
                    check(1'b0, "R6 unexpected done", 128'(result), 128'd0);
                end else begin
                    it = sb.pop_front();
                    check(128'(result) == it.val, it.tag, 128'(result), it.val);
                    check(cyc == it.due, "R4 latency", 128'(cyc), 128'(it.due));
                    check(chk_err == 1'b0, "R7", 128'(chk_err), 128'd0);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [4*ND-1:0] b;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        check(busy == 1'b0 && done == 1'b0, "R8", 128'({busy, done}), 128'd0);
        check(result == '0 && chk_err == 1'b0, "R8", 128'(result), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2: single digit, garbage above the count
        b = rand_bcd();
        b[3:0] = 4'd7;
        launch(b, 1, "R2");
        wait_done();
        @(negedge clk);

        // R1: three digits 123
        b = '0;
        b[11:0] = 12'h123;
        launch(b, 3, "R1");
        wait_done();
        @(negedge clk);

        // R1: four digits forcing a padded top group (1000)
        b = rand_bcd();
        b[15:0] = 16'h1000;
        launch(b, 4, "R1");
        wait_done();
        @(negedge clk);

        // R9: 34 nines
        for (int i = 0; i < ND; i++) b[4*i +: 4] = 4'd9;
        launch(b, 34, "R9");
        wait_done();
        @(negedge clk);

        // R3: count zero gives zero
        b = rand_bcd();
        launch(b, 0, "R3");
        wait_done();
        @(negedge clk);

        // R3: count above the maximum is clamped
        b = rand_bcd();
        launch(b, 40, "R3");
        wait_done();
        @(negedge clk);

        // R1: a one followed by 32 zeros
        b = '0;
        b[4*32 +: 4] = 4'd1;
        launch(b, 33, "R1");
        wait_done();
        @(negedge clk);

        // R6: start while busy is ignored
        b = rand_bcd();
        launch(b, 34, "R6");
        @(negedge clk);
        bcd_in = rand_bcd();
        digit_cnt = CW'(5);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (20) @(negedge clk);
        check(n_done == n_launch, "R6", 128'(n_done), 128'(n_launch));

        // R1/R4/R5: back-to-back runs, each start coinciding with done
        b = rand_bcd();
        launch(b, 1 + int'($urandom_range(0, ND - 1)), "R1");
        for (int n = 0; n < 25; n++) begin
            wait_done();
            b = rand_bcd();
            launch(b, 1 + int'($urandom_range(0, ND - 1)), "R1");
        end
        wait_done();
        repeat (20) @(negedge clk);
        check(n_done == n_launch, "R6", 128'(n_done), 128'(n_launch));
        check(sb.size() == 0, "R4", 128'(sb.size()), 128'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule